// File: doc/BRIEF.md
# Forwarded Write Termination Controller

This block is the master-side control of a bus bridge that forwards write transactions from one bus to another. It accepts one write at a time and requests attempts from an abstract target-bus engine. Each time an attempt ends, the engine reports a termination code, and the block decides from that code whether to try again, to resume the write, or to stop. The write is tagged either as delayed or as posted, and it carries the number of data phases the initiator asked for.

For a delayed write, the termination is turned into a response for the original initiator. A delayed write that keeps being retried by the target is abandoned after a configurable number of attempts. When that happens, the block may raise a single-cycle system-error pulse. A posted write is finished by the bridge on its own, and nothing is reported back. If the target disconnects a posted write, the block starts a continuation attempt, flagged to the engine, that carries the data still left.

The controller has two states. `ST_IDLE` accepts a request (transition *accept*, to `ST_ISSUE`). `ST_ISSUE` holds the attempt request high. From `ST_ISSUE` there are three transitions. *again* stays in `ST_ISSUE` after a retry. *resume* stays in `ST_ISSUE` with the continuation flag set, after a posted disconnect. *finish* returns to `ST_IDLE` on completion, on an abort, or on the limit.

Top module: `fwd_write_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, `req_ready` is 1 and `att_req`, `att_cont`, `rsp_valid`, both status strobes and `syserr` are all 0.
- R2: A request seen with `req_valid`=1 while `req_ready`=1 is accepted. From the next cycle `att_req` is 1 and `req_ready` is 0 until the write finishes.
- R3: Termination codes on `att_term` are 0 normal, 1 retry, 2 disconnect, 3 target abort and 4 master abort. Response codes on `rsp_code` are 1 retry, 2 done, 3 disconnect-with-first-data, 4 target abort and 5 master abort. A delayed write ended by normal (0) or disconnect (2) gives a one-cycle `rsp_valid` in the cycle after `att_done`. The code is 3 when `req_phases` was greater than 1, and 2 otherwise. The block then returns to idle.
- R4: A delayed write that is retried (1), and is below its limit, gives `rsp_valid` with code 1. `att_req` stays 1 and a further attempt follows.
- R5: A delayed write ended by target abort (3) gives response code 4. In the same cycle it pulses both `sts_rx_tabort` and `sts_sig_tabort`. The block then returns to idle.
- R6: A delayed write ended by master abort (4) gives response code 5 and returns to idle, with no status strobes.
- R7: The attempt limit is 2^LIM_LO_LOG2 when `cfg_lim_sel`=0, and 2^LIM_HI_LOG2 when `cfg_lim_sel`=1. The retry that makes the attempt count reach the limit gives no `rsp_valid`, and the block returns to idle.
- R8: On reaching the limit, `syserr` pulses for exactly one cycle, only if `cfg_syserr_en`=1 and `cfg_nondeliv_mask`=0. Otherwise it stays 0.
- R9: The attempt count is cleared when a new write is accepted, so the retries of an earlier write do not count toward the limit of the next one.
- R10: A posted write ended by normal termination returns to idle with no `rsp_valid`.
- R11: A posted write that is retried is repeated with no `rsp_valid` and no `syserr`, whatever the number of retries.
- R12: A posted write ended by disconnect keeps `att_req` at 1 and sets `att_cont` to 1 for the continuation attempt. `att_cont` clears when the write finishes.
- R13: A posted write ended by target abort or master abort returns to idle. It gives no `rsp_valid` and no status strobes, so the data is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New write request present |
| req_posted | input | 1 | 1 = posted write, 0 = delayed write |
| req_phases | input | PH_W | Number of data phases requested by the initiator |
| req_ready | output | 1 | Block idle, request can be taken |
| att_req | output | 1 | Attempt on the target bus requested |
| att_cont | output | 1 | Current attempt continues a disconnected posted write |
| att_done | input | 1 | Engine reports end of an attempt |
| att_term | input | 3 | Termination code of the ended attempt |
| cfg_syserr_en | input | 1 | System-error reporting enable |
| cfg_nondeliv_mask | input | 1 | Suppress system error for undelivered delayed writes |
| cfg_lim_sel | input | 1 | Selects the high attempt limit |
| rsp_valid | output | 1 | One-cycle response to the initiator |
| rsp_code | output | 3 | Response code, valid with rsp_valid |
| sts_rx_tabort | output | 1 | Set strobe for the received-target-abort status bit |
| sts_sig_tabort | output | 1 | Set strobe for the signaled-target-abort status bit |
| syserr | output | 1 | One-cycle system-error pulse |

## Verification
The bench builds the block with LIM_LO_LOG2=3 and LIM_HI_LOG2=5, which gives limits of 8 and 32 attempts. With these values both limit settings, the system-error gating and the counter clearing can be driven to their end points in a few hundred cycles. The default limits of 2^24 and 2^32 would be far out of reach. PH_W stays at its default, because only the single-phase versus multi-phase split matters to the behaviour.

// File: rtl/wt_pkg.sv
package wt_pkg;

    typedef enum logic [2:0] {
        TM_NORMAL = 3'd0,
        TM_RETRY  = 3'd1,
        TM_DISC   = 3'd2,
        TM_TABORT = 3'd3,
        TM_MABORT = 3'd4
    } term_e;

    typedef enum logic [2:0] {
        RS_NONE   = 3'd0,
        RS_RETRY  = 3'd1,
        RS_DONE   = 3'd2,
        RS_DISC   = 3'd3,
        RS_TABORT = 3'd4,
        RS_MABORT = 3'd5
    } rsp_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_AGAIN,
        ACT_RESUME,
        ACT_FINISH
    } act_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } st_e;

endpackage

// File: rtl/wt_attempt_ctr.sv
module wt_attempt_ctr #(
    parameter int LIM_LO_LOG2 = 24,
    parameter int LIM_HI_LOG2 = 32,
    localparam int CNT_W = LIM_HI_LOG2 + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic lim_sel,
    output logic at_last
);
    localparam logic [CNT_W-1:0] ONE    = 1;
    localparam logic [CNT_W-1:0] LIM_LO = ONE << LIM_LO_LOG2;
    localparam logic [CNT_W-1:0] LIM_HI = ONE << LIM_HI_LOG2;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    assign lim     = lim_sel ? LIM_HI : LIM_LO;
    assign at_last = (cnt_q + ONE) >= lim;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= at_last ? '0 : cnt_q + ONE;
        end
    end

    // R9
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/wt_term_decode.sv
module wt_term_decode
    import wt_pkg::*;
(
    input  logic       posted,
    input  logic       multi,
    input  logic [2:0] term,
    input  logic       at_last,
    output act_e       act,
    output logic       rsp_en,
    output rsp_e       rsp,
    output logic       set_tabort,
    output logic       cnt_inc,
    output logic       nondeliv
);
    always_comb begin
        act        = ACT_HOLD;
        rsp_en     = 1'b0;
        rsp        = RS_NONE;
        set_tabort = 1'b0;
        cnt_inc    = 1'b0;
        nondeliv   = 1'b0;
        if (posted) begin
            unique case (term)
                TM_NORMAL, TM_TABORT, TM_MABORT: act = ACT_FINISH;
                TM_RETRY:                        act = ACT_AGAIN;
                TM_DISC:                         act = ACT_RESUME;
                default:                         act = ACT_HOLD;
            endcase
        end else begin
            unique case (term)
                TM_NORMAL, TM_DISC: begin
                    act    = ACT_FINISH;
                    rsp_en = 1'b1;
                    rsp    = multi ? RS_DISC : RS_DONE;
                end
                TM_RETRY: begin
                    cnt_inc = 1'b1;
                    if (at_last) begin
                        act      = ACT_FINISH;
                        nondeliv = 1'b1;
                    end else begin
                        act    = ACT_AGAIN;
                        rsp_en = 1'b1;
                        rsp    = RS_RETRY;
                    end
                end
                TM_TABORT: begin
                    act        = ACT_FINISH;
                    rsp_en     = 1'b1;
                    rsp        = RS_TABORT;
                    set_tabort = 1'b1;
                end
                TM_MABORT: begin
                    act    = ACT_FINISH;
                    rsp_en = 1'b1;
                    rsp    = RS_MABORT;
                end
                default: act = ACT_HOLD;
            endcase
        end
    end
endmodule

// File: rtl/fwd_write_ctrl.sv
module fwd_write_ctrl
    import wt_pkg::*;
#(
    parameter int PH_W        = 8,
    parameter int LIM_LO_LOG2 = 24,
    parameter int LIM_HI_LOG2 = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_posted,
    input  logic [PH_W-1:0] req_phases,
    output logic            req_ready,
    output logic            att_req,
    output logic            att_cont,
    input  logic            att_done,
    input  logic [2:0]      att_term,
    input  logic            cfg_syserr_en,
    input  logic            cfg_nondeliv_mask,
    input  logic            cfg_lim_sel,
    output logic            rsp_valid,
    output logic [2:0]      rsp_code,
    output logic            sts_rx_tabort,
    output logic            sts_sig_tabort,
    output logic            syserr
);
    st_e  state_q, state_d;
    logic posted_q, multi_q;
    logic accept, decide, at_last;
    act_e act;
    logic d_rsp_en, d_set_tabort, d_cnt_inc, d_nondeliv;
    rsp_e d_rsp;

    assign req_ready = (state_q == ST_IDLE);
    assign att_req   = (state_q == ST_ISSUE);
    assign accept    = req_ready && req_valid;
    assign decide    = att_req && att_done;

    wt_term_decode u_dec (
        .posted     (posted_q),
        .multi      (multi_q),
        .term       (att_term),
        .at_last    (at_last),
        .act        (act),
        .rsp_en     (d_rsp_en),
        .rsp        (d_rsp),
        .set_tabort (d_set_tabort),
        .cnt_inc    (d_cnt_inc),
        .nondeliv   (d_nondeliv)
    );

    wt_attempt_ctr #(
        .LIM_LO_LOG2 (LIM_LO_LOG2),
        .LIM_HI_LOG2 (LIM_HI_LOG2)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .inc     (decide && d_cnt_inc),
        .lim_sel (cfg_lim_sel),
        .at_last (at_last)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_ISSUE;
            ST_ISSUE: if (decide && act == ACT_FINISH) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            posted_q       <= 1'b0;
            multi_q        <= 1'b0;
            att_cont       <= 1'b0;
            rsp_valid      <= 1'b0;
            rsp_code       <= RS_NONE;
            sts_rx_tabort  <= 1'b0;
            sts_sig_tabort <= 1'b0;
            syserr         <= 1'b0;
        end else begin
            rsp_valid      <= decide && d_rsp_en;
            rsp_code       <= (decide && d_rsp_en) ? d_rsp : RS_NONE;
            sts_rx_tabort  <= decide && d_set_tabort;
            sts_sig_tabort <= decide && d_set_tabort;
            syserr         <= decide && d_nondeliv && cfg_syserr_en && !cfg_nondeliv_mask;
            if (accept) begin
                posted_q <= req_posted;
                multi_q  <= (req_phases > PH_W'(1));
                att_cont <= 1'b0;
            end else if (decide) begin
                if (act == ACT_RESUME)      att_cont <= 1'b1;
                else if (act == ACT_FINISH) att_cont <= 1'b0;
            end
        end
    end

    // R8
    syserr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        syserr |-> $past(cfg_syserr_en && !cfg_nondeliv_mask));
    // R8
    syserr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        syserr |=> !syserr);
    // R7
    syserr_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        syserr |-> (!rsp_valid && req_ready));
    // R5
    tabort_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rx_tabort |-> (sts_sig_tabort && rsp_valid && rsp_code == RS_TABORT));
    // R13
    posted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !$past(posted_q));
    // R2
    attempt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(att_req) |-> $past(att_done));
    // R12
    cont_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        att_cont |-> att_req);

endmodule

// File: tb/test_fwd_write_ctrl.sv
module test_fwd_write_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_posted = 1'b0;
    logic [7:0] req_phases = 8'd1;
    logic       req_ready, att_req, att_cont;
    logic       att_done = 1'b0;
    logic [2:0] att_term = 3'd0;
    logic       cfg_syserr_en = 1'b1, cfg_nondeliv_mask = 1'b0, cfg_lim_sel = 1'b0;
    logic       rsp_valid, sts_rx_tabort, sts_sig_tabort, syserr;
    logic [2:0] rsp_code;

    int errors = 0;
    int checks = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    fwd_write_ctrl #(.PH_W(8), .LIM_LO_LOG2(3), .LIM_HI_LOG2(5)) i_fwd_write_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_posted(req_posted),
        .req_phases(req_phases), .req_ready(req_ready), .att_req(att_req),
        .att_cont(att_cont), .att_done(att_done), .att_term(att_term),
        .cfg_syserr_en(cfg_syserr_en), .cfg_nondeliv_mask(cfg_nondeliv_mask),
        .cfg_lim_sel(cfg_lim_sel), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .sts_rx_tabort(sts_rx_tabort), .sts_sig_tabort(sts_sig_tabort), .syserr(syserr)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic start_req(input bit posted, input bit multi);
        @(negedge clk);
        req_valid  = 1'b1;
        req_posted = posted;
        req_phases = multi ? 8'd4 : 8'd1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic attempt(input logic [2:0] term);
        att_done = 1'b1;
        att_term = term;
        @(negedge clk);
        att_done = 1'b0;
    endtask

    task automatic run_limit(input bit sel, input bit en, input bit mask, input int lim);
        cfg_lim_sel = sel; cfg_syserr_en = en; cfg_nondeliv_mask = mask;
        start_req(1'b0, 1'b0);
        for (int i = 0; i < lim - 1; i++) begin
            attempt(3'd1);
            check("R4 retry response", int'(rsp_valid && rsp_code == 3'd1), 1);
        end
        attempt(3'd1);
        check("R7 no response at limit", int'(rsp_valid), 0);
        check("R7 idle at limit", int'(req_ready), 1);
        check("R8 syserr gating", int'(syserr), int'(en && !mask));
        @(negedge clk);
        check("R8 syserr single cycle", int'(syserr), 0);
        cfg_lim_sel = 1'b0; cfg_syserr_en = 1'b1; cfg_nondeliv_mask = 1'b0;
    endtask

    // {posted, multi, term[2:0], exp_rv, exp_code[2:0], exp_sts, exp_busy, exp_cont}
    localparam logic [11:0] VEC [12] = '{
        {1'b0, 1'b0, 3'd0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b1, 3'd0, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b1, 3'd2, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b0, 3'd2, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0},
        {1'b0, 1'b0, 3'd1, 1'b1, 3'd1, 1'b0, 1'b1, 1'b0},
        {1'b0, 1'b1, 3'd3, 1'b1, 3'd4, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b0, 3'd4, 1'b1, 3'd5, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b1, 3'd1, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0},
        {1'b1, 1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1},
        {1'b1, 1'b0, 3'd3, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
        {1'b1, 1'b1, 3'd4, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready in reset", int'(req_ready), 1);
        check("R1 outputs quiet in reset",
              int'({att_req, att_cont, rsp_valid, sts_rx_tabort, sts_sig_tabort, syserr}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", int'(req_ready), 1);
        check("R1 no attempt after reset", int'(att_req), 0);

        // R2 accept
        start_req(1'b0, 1'b0);
        check("R2 attempt after accept", int'(att_req), 1);
        check("R2 not ready while busy", int'(req_ready), 0);
        attempt(3'd0);

        // Vector table: R3 R4 R5 R6 R10 R11 R12 R13
        for (int v = 0; v < 12; v++) begin
            logic [11:0] e;
            e = VEC[v];
            start_req(e[11], e[10]);
            attempt(e[9:7]);
            check($sformatf("R3-R13 vec%0d rsp_valid", v), int'(rsp_valid), int'(e[6]));
            if (e[6]) check($sformatf("R3 vec%0d rsp_code", v), int'(rsp_code), int'(e[5:3]));
            check($sformatf("R5 vec%0d rx_tabort", v), int'(sts_rx_tabort), int'(e[2]));
            check($sformatf("R5 vec%0d sig_tabort", v), int'(sts_sig_tabort), int'(e[2]));
            check($sformatf("R12 vec%0d busy", v), int'(att_req), int'(e[1]));
            check($sformatf("R12 vec%0d cont", v), int'(att_cont), int'(e[0]));
            if (e[1]) begin
                attempt(3'd0);
                check($sformatf("R10 vec%0d closed", v), int'(req_ready), 1);
                check($sformatf("R12 vec%0d cont cleared", v), int'(att_cont), 0);
                if (!e[11]) check("R3 close-out done", int'(rsp_valid && rsp_code == 3'd2), 1);
                else        check("R10 posted close silent", int'(rsp_valid), 0);
            end
        end

        // R7 and R8: both limits, gating combinations
        run_limit(1'b0, 1'b1, 1'b0, 8);
        run_limit(1'b0, 1'b1, 1'b1, 8);
        run_limit(1'b0, 1'b0, 1'b0, 8);
        run_limit(1'b1, 1'b1, 1'b0, 32);

        // R9: counter cleared on new write
        start_req(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) attempt(3'd1);
        attempt(3'd0);
        check("R9 first write done", int'(rsp_code), 2);
        start_req(1'b0, 1'b0);
        for (int i = 0; i < 7; i++) begin
            attempt(3'd1);
            check("R9 retry below fresh limit", int'(rsp_valid && rsp_code == 3'd1), 1);
        end
        check("R9 still busy", int'(att_req), 1);
        attempt(3'd0);

        // R11: posted retried past the delayed limit
        start_req(1'b1, 1'b0);
        for (int i = 0; i < 20; i++) begin
            attempt(3'd1);
            check("R11 posted retry silent", int'(rsp_valid || syserr), 0);
        end
        check("R11 posted still busy", int'(att_req), 1);
        // R12: retry of a continuation keeps the flag
        attempt(3'd2);
        attempt(3'd1);
        check("R12 cont kept across retry", int'(att_cont), 1);
        attempt(3'd0);
        check("R12 cont cleared at end", int'(att_cont), 0);
        check("R10 idle after posted normal", int'(req_ready), 1);

        finish_run();
    end
endmodule